// File: doc/BRIEF.md
# Synthesizer Serial Configuration Register Port

This block is the write-only configuration port of a fractional-N frequency synthesizer. A host shifts 24-bit frames into it over a three-wire link made of a serial clock, a serial data line and a load strobe. The three wires are brought into the system clock domain, bits are collected while the load strobe is low, and the rising edge of the load strobe commits the collected frame to one of four configuration registers. Those registers hold the fractional numerator, the integer divide word together with the normal pump current, the divider and control settings, and the fast-lock settings.

The numerator is double-buffered. A numerator write waits in a shadow register and becomes visible only when the integer register is written. At that moment numerator and integer change on the same clock edge and a one-cycle frequency-change strobe is raised for the loop control logic. Frames whose address is not one of the four registers are dropped. A sticky flag shows when every register has been written at least once since reset, because the register contents have no defined meaning before that.

Top module: `synth_sif_regs`

## Requirements
- R1: A frame is 24 bits, each sampled on a rising edge of `ser_clk_i` while `ser_load_i` is low. The first 20 bits sent are data D19 down to D0 and the last 4 bits are the address, most significant bit first.
- R2: When more than 24 bits are clocked in before the load strobe rises, only the last 24 bits are decoded.
- R3: A frame is decoded on the rising edge of `ser_load_i`. Its effect shows at the outputs from the fourth rising edge of `clk` that samples the load strobe high, counting the first such edge as one, and no output changes in any cycle that does not follow a decoded frame.
- R4: Address 1 loads an 18-bit numerator from D17:D0 into a pending register that the outputs do not show. Address 2 loads the pump current from D18:D15 and the integer from D14:D0. On the same edge it copies the pending numerator to `num_o`.
- R5: Address 3 sets pump tri-state from D15, dither enable from D14, lock window from D13:D12, lock-detect mode from D11, pump polarity from D10, prescaler select from D9:D8 and reference divide from D7:D0.
- R6: Address 4 sets fast-lock enable from D16, fast pump current from D15:D13 and the fast timer count from D12:D0.
- R7: `freq_evt_o` is high for exactly one clock cycle, on the edge where an address 2 frame commits, and is low at all other times.
- R8: Frames with address 0 or with an address from 5 to 15 change no output and raise no strobe.
- R9: `cfg_valid_o` goes high once addresses 1, 2, 3 and 4 have each been written since reset, and then stays high until the next reset.
- R10: A synchronous reset clears every output and the pending numerator to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial bit clock |
| ser_dat_i | input | 1 | Serial data |
| ser_load_i | input | 1 | Load strobe; low while shifting, rising edge commits |
| num_o | output | 18 | Committed fractional numerator (two's complement) |
| int_o | output | 15 | Committed integer divide word |
| pump_cur_o | output | 4 | Normal pump current code |
| pump_hiz_o | output | 1 | Pump output tri-state |
| dith_en_o | output | 1 | Modulator dither enable |
| lock_win_o | output | 2 | Lock-detect window select |
| lock_mode_o | output | 1 | Lock-detect mode select |
| pump_pol_o | output | 1 | Pump polarity |
| pre_sel_o | output | 2 | Prescaler select |
| ref_div_o | output | 8 | Reference divide ratio |
| fast_en_o | output | 1 | Fast-lock enable |
| fast_cur_o | output | 3 | Fast pump current code |
| fast_cnt_o | output | 13 | Fast-lock timer count |
| freq_evt_o | output | 1 | One-cycle frequency-change strobe |
| cfg_valid_o | output | 1 | All four registers written since reset |

## Verification
A wrong shift count, address decode or bit slice shows on the decoded fields on the fourth clock edge after the load strobe rises, so a cycle-exact reference model catches it at once. A corrupted shadow register stays hidden until the next address 2 write, so the bench follows each numerator write with an integer write and also checks the gap between them, when `num_o` must not move. A broken written-mask shows on `cfg_valid_o` only once the last register is written, and a reset taken between a numerator write and an integer write exposes a shadow register that reset failed to clear.

// File: rtl/synth_sif_pkg.sv
package synth_sif_pkg;

    localparam int FRAME_W = 24;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = FRAME_W - ADDR_W;
    localparam int NUM_W   = 18;
    localparam int INT_W   = 15;
    localparam int PCUR_W  = 4;
    localparam int FCUR_W  = 3;
    localparam int FCNT_W  = 13;
    localparam int RDIV_W  = 8;
    localparam int NREGS   = 4;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_NUM  = 4'd1,
        ADDR_INT  = 4'd2,
        ADDR_DIV  = 4'd3,
        ADDR_FAST = 4'd4
    } reg_addr_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] addr;
    } frame_t;

    typedef struct packed {
        logic [PCUR_W-1:0] pump_cur;
        logic [INT_W-1:0]  int_word;
    } int_cfg_t;

    typedef struct packed {
        logic              pump_hiz;
        logic              dith_en;
        logic [1:0]        lock_win;
        logic              lock_mode;
        logic              pump_pol;
        logic [1:0]        pre_sel;
        logic [RDIV_W-1:0] ref_div;
    } div_cfg_t;

    typedef struct packed {
        logic              fast_en;
        logic [FCUR_W-1:0] fast_cur;
        logic [FCNT_W-1:0] fast_cnt;
    } fast_cfg_t;

    function automatic int_cfg_t unpack_int(input logic [DATA_W-1:0] d);
        int_cfg_t r;
        r.pump_cur = d[18:15];
        r.int_word = d[14:0];
        return r;
    endfunction

    function automatic div_cfg_t unpack_div(input logic [DATA_W-1:0] d);
        div_cfg_t r;
        r.pump_hiz  = d[15];
        r.dith_en   = d[14];
        r.lock_win  = d[13:12];
        r.lock_mode = d[11];
        r.pump_pol  = d[10];
        r.pre_sel   = d[9:8];
        r.ref_div   = d[7:0];
        return r;
    endfunction

    function automatic fast_cfg_t unpack_fast(input logic [DATA_W-1:0] d);
        fast_cfg_t r;
        r.fast_en  = d[16];
        r.fast_cur = d[15:13];
        r.fast_cnt = d[12:0];
        return r;
    endfunction

    function automatic logic addr_known(input logic [ADDR_W-1:0] a);
        return (a == ADDR_NUM) || (a == ADDR_INT) ||
               (a == ADDR_DIV) || (a == ADDR_FAST);
    endfunction

endpackage

// File: rtl/sif_sync.sv
module sif_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] pipe [STAGES];
    logic [W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= '0;
        else     pipe[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[s] <= '0;
            else     pipe[s] <= pipe[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= '0;
        else     last_q <= pipe[STAGES-1];
    end

    assign level_o = pipe[STAGES-1];
    assign rise_o  = pipe[STAGES-1] & ~last_q;
endmodule

// File: rtl/sif_shifter.sv
module sif_shifter
    import synth_sif_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   bit_stb,
    input  logic   bit_val,
    input  logic   load_lvl,
    input  logic   load_rise,
    output logic   frame_vld,
    output frame_t frame
);
    logic [FRAME_W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
        end else if (bit_stb && !load_lvl) begin
            sreg <= {sreg[FRAME_W-2:0], bit_val};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_vld <= 1'b0;
            frame     <= '0;
        end else begin
            frame_vld <= load_rise;
            if (load_rise) frame <= frame_t'(sreg);
        end
    end
endmodule

// File: rtl/synth_reg_bank.sv
module synth_reg_bank
    import synth_sif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_vld,
    input  frame_t            frame,
    output logic [NUM_W-1:0]  num_q,
    output int_cfg_t          int_q,
    output div_cfg_t          div_q,
    output fast_cfg_t         fast_q,
    output logic              evt_q,
    output logic              all_written
);
    logic [NUM_W-1:0] num_pend;
    logic [NREGS-1:0] written;
    reg_addr_e        sel;

    assign sel = reg_addr_e'(frame.addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            num_pend <= '0;
            num_q    <= '0;
            int_q    <= '0;
            div_q    <= '0;
            fast_q   <= '0;
            evt_q    <= 1'b0;
            written  <= '0;
        end else begin
            evt_q <= 1'b0;
            if (frame_vld && addr_known(frame.addr)) begin
                written[frame.addr - 1'b1] <= 1'b1;
                case (sel)
                    ADDR_NUM:  num_pend <= frame.data[NUM_W-1:0];
                    ADDR_INT: begin
                        num_q <= num_pend;
                        int_q <= unpack_int(frame.data);
                        evt_q <= 1'b1;
                    end
                    ADDR_DIV:  div_q  <= unpack_div(frame.data);
                    ADDR_FAST: fast_q <= unpack_fast(frame.data);
                    default: ;
                endcase
            end
        end
    end

    assign all_written = &written;
endmodule

// File: rtl/synth_sif_regs.sv
module synth_sif_regs
    import synth_sif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              ser_load_i,
    output logic [NUM_W-1:0]  num_o,
    output logic [INT_W-1:0]  int_o,
    output logic [PCUR_W-1:0] pump_cur_o,
    output logic              pump_hiz_o,
    output logic              dith_en_o,
    output logic [1:0]        lock_win_o,
    output logic              lock_mode_o,
    output logic              pump_pol_o,
    output logic [1:0]        pre_sel_o,
    output logic [RDIV_W-1:0] ref_div_o,
    output logic              fast_en_o,
    output logic [FCUR_W-1:0] fast_cur_o,
    output logic [FCNT_W-1:0] fast_cnt_o,
    output logic              freq_evt_o,
    output logic              cfg_valid_o
);
    logic [2:0] lvl, rise;
    logic       frame_vld;
    frame_t     frame;
    int_cfg_t   int_q;
    div_cfg_t   div_q;
    fast_cfg_t  fast_q;

    sif_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({ser_load_i, ser_dat_i, ser_clk_i}),
        .level_o (lvl),
        .rise_o  (rise)
    );

    sif_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .bit_stb   (rise[0]),
        .bit_val   (lvl[1]),
        .load_lvl  (lvl[2]),
        .load_rise (rise[2]),
        .frame_vld (frame_vld),
        .frame     (frame)
    );

    synth_reg_bank u_bank (
        .clk         (clk),
        .rst         (rst),
        .frame_vld   (frame_vld),
        .frame       (frame),
        .num_q       (num_o),
        .int_q       (int_q),
        .div_q       (div_q),
        .fast_q      (fast_q),
        .evt_q       (freq_evt_o),
        .all_written (cfg_valid_o)
    );

    assign int_o       = int_q.int_word;
    assign pump_cur_o  = int_q.pump_cur;
    assign pump_hiz_o  = div_q.pump_hiz;
    assign dith_en_o   = div_q.dith_en;
    assign lock_win_o  = div_q.lock_win;
    assign lock_mode_o = div_q.lock_mode;
    assign pump_pol_o  = div_q.pump_pol;
    assign pre_sel_o   = div_q.pre_sel;
    assign ref_div_o   = div_q.ref_div;
    assign fast_en_o   = fast_q.fast_en;
    assign fast_cur_o  = fast_q.fast_cur;
    assign fast_cnt_o  = fast_q.fast_cnt;
endmodule

// File: rtl/synth_sif_regs_chk.sv
module synth_sif_regs_chk (
    input logic        clk,
    input logic        rst,
    input logic        frame_vld,
    input logic [3:0]  frame_addr,
    input logic [17:0] num_o,
    input logic [18:0] int_word,
    input logic [32:0] cfg_word,
    input logic        freq_evt_o,
    input logic        cfg_valid_o
);
    // R7: strobe lasts a single cycle
    assert_evt_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        freq_evt_o |=> !freq_evt_o);

    // R7: strobe only follows an address 2 frame
    assert_evt_source_R7: assert property (@(posedge clk) disable iff (rst)
        freq_evt_o |-> ($past(frame_vld) && $past(frame_addr) == 4'd2));

    // R4: numerator moves only together with the commit strobe
    assert_num_commit_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(num_o) |-> freq_evt_o);

    // R4: integer word moves only together with the commit strobe
    assert_int_commit_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(int_word) |-> freq_evt_o);

    // R8: unknown addresses leave everything untouched
    assert_bad_addr_R8: assert property (@(posedge clk) disable iff (rst)
        (frame_vld && (frame_addr == 4'd0 || frame_addr > 4'd4)) |=>
        ($stable(cfg_word) && $stable(num_o) && $stable(int_word) &&
         !freq_evt_o && $stable(cfg_valid_o)));

    // R3: no output moves without a decoded frame
    assert_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !frame_vld |=> ($stable(cfg_word) && $stable(num_o) &&
                        $stable(int_word) && $stable(cfg_valid_o)));

    // R9: the valid flag never drops outside reset
    assert_valid_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        !$fell(cfg_valid_o));
endmodule

bind synth_sif_regs synth_sif_regs_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_vld   (frame_vld),
    .frame_addr  (frame.addr),
    .num_o       (num_o),
    .int_word    ({pump_cur_o, int_o}),
    .cfg_word    ({pump_hiz_o, dith_en_o, lock_win_o, lock_mode_o, pump_pol_o,
                   pre_sel_o, ref_div_o, fast_en_o, fast_cur_o, fast_cnt_o}),
    .freq_evt_o  (freq_evt_o),
    .cfg_valid_o (cfg_valid_o)
);

// File: tb/synth_sif_regs_bench.sv
module synth_sif_regs_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_load = 1'b0;

    logic [17:0] num_o;
    logic [14:0] int_o;
    logic [3:0]  pump_cur_o;
    logic        pump_hiz_o, dith_en_o, lock_mode_o, pump_pol_o;
    logic [1:0]  lock_win_o, pre_sel_o;
    logic [7:0]  ref_div_o;
    logic        fast_en_o;
    logic [2:0]  fast_cur_o;
    logic [12:0] fast_cnt_o;
    logic        freq_evt_o, cfg_valid_o;

    always #4 clk = ~clk;

    synth_sif_regs u_synth_sif_regs (
        .clk(clk), .rst(rst), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
        .ser_load_i(ser_load), .num_o(num_o), .int_o(int_o),
        .pump_cur_o(pump_cur_o), .pump_hiz_o(pump_hiz_o), .dith_en_o(dith_en_o),
        .lock_win_o(lock_win_o), .lock_mode_o(lock_mode_o),
        .pump_pol_o(pump_pol_o), .pre_sel_o(pre_sel_o), .ref_div_o(ref_div_o),
        .fast_en_o(fast_en_o), .fast_cur_o(fast_cur_o), .fast_cnt_o(fast_cnt_o),
        .freq_evt_o(freq_evt_o), .cfg_valid_o(cfg_valid_o)
    );

    int tests = 0, fails = 0;
    int cyc = 0;
    int evt_cnt = 0;
    bit done = 0;

    // behavioural reference state
    logic [19:0] m_num, m_pend, m_int, m_div, m_fast;
    bit          m_w1, m_w2, m_w3, m_w4;
    bit          pend_on = 0;
    int          pend_cyc;
    logic [3:0]  pend_addr;
    logic [19:0] pend_data;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h cyc=%0d", tag, act, exp, cyc);
        end
    endtask

    task automatic model_clear();
        m_num = 0; m_pend = 0; m_int = 0; m_div = 0; m_fast = 0;
        m_w1 = 0; m_w2 = 0; m_w3 = 0; m_w4 = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (freq_evt_o) evt_cnt++;
    end

    always @(negedge clk) begin
        if (rst) begin
            model_clear();
        end else begin
            bit exp_evt;
            exp_evt = 0;
            if (pend_on && cyc == pend_cyc) begin
                pend_on = 0;
                case (pend_addr)
                    4'd1: begin m_pend = pend_data; m_w1 = 1; end
                    4'd2: begin m_num = m_pend; m_int = pend_data; m_w2 = 1; exp_evt = 1; end
                    4'd3: begin m_div = pend_data; m_w3 = 1; end
                    4'd4: begin m_fast = pend_data; m_w4 = 1; end
                    default: ;
                endcase
            end
            check("R4 num", 32'(num_o), 32'(m_num[17:0]));
            check("R4 int", 32'({pump_cur_o, int_o}), 32'(m_int[18:0]));
            check("R5 div", 32'({pump_hiz_o, dith_en_o, lock_win_o, lock_mode_o,
                                 pump_pol_o, pre_sel_o, ref_div_o}), 32'(m_div[15:0]));
            check("R6 fast", 32'({fast_en_o, fast_cur_o, fast_cnt_o}), 32'(m_fast[16:0]));
            check("R7 evt", 32'(freq_evt_o), 32'(exp_evt));
            check("R9 valid", 32'(cfg_valid_o), 32'(m_w1 & m_w2 & m_w3 & m_w4));
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b);
        ser_dat = b; ser_clk = 1'b0;
        wait_cyc(3);
        ser_clk = 1'b1;
        wait_cyc(3);
    endtask

    // extra: number of leading junk bits (value 1) sent before the frame
    task automatic send_frame(input logic [3:0] addr, input logic [19:0] data, input int extra);
        logic [23:0] f;
        f = {data, addr};
        for (int i = 0; i < extra; i++) send_bit(1'b1);
        for (int i = 23; i >= 0; i--) send_bit(f[i]);
        ser_clk = 1'b0;
        wait_cyc(3);
        ser_load = 1'b1;
        pend_addr = addr; pend_data = data; pend_cyc = cyc + 4; pend_on = 1;
        wait_cyc(5);
        ser_load = 1'b0;
        wait_cyc(6);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(2);
    endtask

    initial begin
        int e0;
        model_clear();
        #1;
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(2);
        // R10 reset state
        check("R10 num", 32'(num_o), 0);
        check("R10 ref", 32'(ref_div_o), 0);
        check("R10 valid", 32'(cfg_valid_o), 0);
        check("R10 evt", 32'(freq_evt_o), 0);

        // R5 / R1 divider settings
        send_frame(4'd3, 20'h06528, 0);
        check("R5 ref_div", 32'(ref_div_o), 32'h28);
        check("R5 pre_sel", 32'(pre_sel_o), 1);
        check("R5 lock_win", 32'(lock_win_o), 2);
        check("R5 dith", 32'(dith_en_o), 1);
        check("R5 pol", 32'(pump_pol_o), 1);
        check("R5 hiz", 32'(pump_hiz_o), 0);

        // R6 fast-lock settings
        send_frame(4'd4, 20'h1AABC, 0);
        check("R6 en", 32'(fast_en_o), 1);
        check("R6 cur", 32'(fast_cur_o), 5);
        check("R6 cnt", 32'(fast_cnt_o), 32'hABC);

        // R4 numerator stays pending
        send_frame(4'd1, 20'h02666, 0);
        check("R4 pending num", 32'(num_o), 0);
        check("R9 not yet", 32'(cfg_valid_o), 0);

        // R4 / R7 commit
        e0 = evt_cnt;
        send_frame(4'd2, 20'h281D1, 0);
        check("R4 num", 32'(num_o), 32'h02666);
        check("R4 int", 32'(int_o), 465);
        check("R4 pcur", 32'(pump_cur_o), 5);
        check("R7 one strobe", 32'(evt_cnt - e0), 1);
        check("R9 valid", 32'(cfg_valid_o), 1);

        // negative numerator
        send_frame(4'd1, 20'h23333, 0);
        send_frame(4'd2, 20'h781D5, 0);
        check("R4 neg num", 32'(num_o), 32'h23333);
        check("R4 int2", 32'(int_o), 469);
        check("R4 pcur2", 32'(pump_cur_o), 15);

        // R2 over-length frame
        send_frame(4'd3, 20'h080FF, 6);
        check("R2 ref_div", 32'(ref_div_o), 32'hFF);
        check("R2 hiz", 32'(pump_hiz_o), 1);
        check("R2 dith", 32'(dith_en_o), 0);

        // R8 unknown addresses
        e0 = evt_cnt;
        send_frame(4'd0, 20'hFFFFF, 0);
        send_frame(4'd5, 20'hFFFFF, 0);
        send_frame(4'd15, 20'h00000, 0);
        check("R8 ref_div", 32'(ref_div_o), 32'hFF);
        check("R8 num", 32'(num_o), 32'h23333);
        check("R8 fast", 32'(fast_cnt_o), 32'hABC);
        check("R8 no strobe", 32'(evt_cnt - e0), 0);

        // R7 integer write alone recommits the same numerator
        e0 = evt_cnt;
        send_frame(4'd2, 20'h00010, 0);
        check("R7 strobe", 32'(evt_cnt - e0), 1);
        check("R4 num kept", 32'(num_o), 32'h23333);
        check("R4 int3", 32'(int_o), 16);

        // R10 reset clears the pending numerator
        send_frame(4'd1, 20'h11111, 0);
        do_reset();
        check("R10 valid cleared", 32'(cfg_valid_o), 0);
        send_frame(4'd2, 20'h00007, 0);
        check("R10 pend cleared", 32'(num_o), 0);
        check("R10 int", 32'(int_o), 7);
        check("R9 partial", 32'(cfg_valid_o), 0);

        wait_cyc(10);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule